// File: doc/BRIEF.md
# Acquisition Trigger Detector

This block decides the moment an acquisition may start. It watches two asynchronous one-bit inputs: a logic-level trigger line and the result of an external analog comparator. A 16-bit control word, written through a simple strobe-and-data port, sets four things: which input is used, whether the input is sensed by edge or by level, the sense of that edge or level, and whether triggering is armed at all.

Each input passes through a two-flop synchroniser. The selected input is then inverted if the polarity bit asks for it. The result goes to one of two paths. In edge mode the block gives a one-clock pulse for each qualifying transition. In level mode it holds its output high for as long as the condition lasts. The output is registered and goes straight to the acquisition sequencer.

If a write changes the source or the polarity, the edge history is thrown away. This stops the flip in the selected signal from being mistaken for a real edge. To disarm the block, software writes the word twice with the enable bit cleared: once with the analog source selected and once with the logic-level source selected.

Top module: `acq_trig_detect`

## Requirements
- R1: While reset is asserted, and until a control word is written after reset, `trig_out` is low whatever the inputs do. The control word resets to all zeros, which means disarmed, comparator source, edge sensing, rising.
- R2: Control bit 0 is the arm bit. After a write with bit 0 = 0, `trig_out` stays low for any input activity.
- R3: Control bit 1 = 0 selects edge sensing. Each qualifying transition of the selected input gives `trig_out` high for exactly one clock. The pulse appears at the third rising clock edge after the input changes: two synchroniser edges, then the output register.
- R4: Control bit 1 = 1 selects level sensing. `trig_out` follows the qualified condition with the same three-edge latency and stays high as long as the condition holds.
- R5: Control bit 2 = 1 selects a falling edge in edge mode and the condition "input low" (below threshold) in level mode. Control bit 2 = 0 selects a rising edge and "input high" (above threshold).
- R6: Control bit 4 = 1 selects the logic-level input `ttl_in`. Control bit 4 = 0 selects the comparator input `cmp_in`. The input that is not selected has no effect on `trig_out`.
- R7: A write that changes bit 2 or bit 4 clears the edge history. The change in the selected signal caused by the new setting produces no pulse. Detection works normally from the following cycle.
- R8: After the two disarm writes (0x0002 with the analog source, then 0x0012 with the logic-level source), `trig_out` stays low while either input toggles.
- R9: Control bits 3 and 5 to 15 are ignored. A word with them set behaves exactly like the same word with them cleared.
- R10: A control word captured at a clock edge decides the output computed at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_data | input | 16 | Control word: bit0 arm, bit1 level, bit2 falling/below, bit4 logic-level source |
| ttl_in | input | 1 | Asynchronous logic-level trigger input |
| cmp_in | input | 1 | Asynchronous analog comparator result |
| trig_out | output | 1 | Trigger pulse (edge mode) or held qualifier (level mode) |

## Verification
The properties assume that `cfg_wr` is a single-cycle, synchronous strobe whose data is stable at the capturing edge. They also assume that the trigger inputs may change at any time, because the synchroniser absorbs that. The history-clear property further assumes that no second write turns on level mode in the cycle right after a source or polarity change.

The stimulus drives every input half a period away from the capturing edge. Random control writes are rare, so edge and level runs last long enough to be observed. Directed sequences cover the polarity flip, the source swap and the two-write disarm.

// File: rtl/trig_pkg.sv
package trig_pkg;
  // Bit positions of the control word decoded by the detector
  localparam int unsigned ARM_BIT   = 0;
  localparam int unsigned LEVEL_BIT = 1;
  localparam int unsigned NEG_BIT   = 2;
  localparam int unsigned SRC_BIT   = 4;

  // Index of each input inside the synchroniser bus
  localparam int unsigned IDX_CMP = 0;
  localparam int unsigned IDX_TTL = 1;
  localparam int unsigned N_SRC   = 2;

  typedef struct packed {
    logic src_ttl;
    logic neg_sense;
    logic level_mode;
    logic armed;
  } trig_cfg_t;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg
  import trig_pkg::*;
#(
  parameter int unsigned CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output trig_cfg_t         cfg_q,
  output logic              hist_clr
);
  localparam logic [CTRL_W-1:0] USED_MASK =
    (CTRL_W'(1) << ARM_BIT) | (CTRL_W'(1) << LEVEL_BIT) |
    (CTRL_W'(1) << NEG_BIT) | (CTRL_W'(1) << SRC_BIT);

  trig_cfg_t wr_cfg;
  logic      unused_ctrl_bits;

  always_comb begin
    wr_cfg.armed      = wr_data[ARM_BIT];
    wr_cfg.level_mode = wr_data[LEVEL_BIT];
    wr_cfg.neg_sense  = wr_data[NEG_BIT];
    wr_cfg.src_ttl    = wr_data[SRC_BIT];
  end

  assign unused_ctrl_bits = ^(wr_data & ~USED_MASK);

  // History must be dropped when the selected, polarity-corrected signal can jump
  always_comb begin
    hist_clr = wr_en &&
               ((wr_cfg.src_ttl   != cfg_q.src_ttl) ||
                (wr_cfg.neg_sense != cfg_q.neg_sense));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_cfg;
  end
endmodule

// File: rtl/trig_qualify.sv
module trig_qualify
  import trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  trig_cfg_t        cfg,
  input  logic             hist_clr,
  input  logic [N_SRC-1:0] src_sync,
  output logic             qual_sel,
  output logic             trig_out
);
  logic prev_q, prev_d;
  logic hist_ok_q, hist_ok_d;
  logic out_d;
  logic raw_sel;
  logic edge_hit;

  always_comb begin
    raw_sel  = cfg.src_ttl ? src_sync[IDX_TTL] : src_sync[IDX_CMP];
    qual_sel = raw_sel ^ cfg.neg_sense;
  end

  always_comb begin
    edge_hit  = qual_sel && !prev_q && hist_ok_q;
    prev_d    = qual_sel;
    hist_ok_d = !hist_clr;
    if (!cfg.armed)          out_d = 1'b0;
    else if (cfg.level_mode) out_d = qual_sel;
    else                     out_d = edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      hist_ok_q <= 1'b0;
      trig_out  <= 1'b0;
    end else begin
      prev_q    <= prev_d;
      hist_ok_q <= hist_ok_d;
      trig_out  <= out_d;
    end
  end
endmodule

// File: rtl/acq_trig_detect.sv
module acq_trig_detect
  import trig_pkg::*;
#(
  parameter int unsigned CTRL_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_data,
  input  logic              ttl_in,
  input  logic              cmp_in,
  output logic              trig_out
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic [N_SRC-1:0]      src_raw;
  logic [N_SRC-1:0]      src_sync;
  trig_cfg_t             cfg_q;
  logic                  hist_clr;
  logic                  qual_sel;

  // Reset asserts at once and is released after RST_STAGES clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  always_comb begin
    src_raw          = '0;
    src_raw[IDX_CMP] = cmp_in;
    src_raw[IDX_TTL] = ttl_in;
  end

  trig_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (src_raw),
    .dout (src_sync)
  );

  trig_cfg_reg #(.CTRL_W(CTRL_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_data),
    .cfg_q   (cfg_q),
    .hist_clr(hist_clr)
  );

  trig_qualify u_qual (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cfg     (cfg_q),
    .hist_clr(hist_clr),
    .src_sync(src_sync),
    .qual_sel(qual_sel),
    .trig_out(trig_out)
  );
endmodule

// File: rtl/acq_trig_detect_chk.sv
module acq_trig_detect_chk #(
  parameter int unsigned CTRL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [CTRL_W-1:0] cfg_data,
  input logic [3:0]        cfg_q,
  input logic              qual_sel,
  input logic              trig_out
);
  // cfg_q packing: [0] armed, [1] level, [2] negative sense, [3] ttl source
  logic unused_chk_bits;
  assign unused_chk_bits = ^cfg_data;

  // R2: a disarmed word yields a quiet output at the next edge
  p_disarmed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[0] |=> !trig_out);

  // R3: an edge-mode pulse lasts one clock when the word is left alone
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out && !cfg_q[1] && !cfg_wr) |=> !trig_out);

  // R4: an armed level mode reports a held qualified condition
  p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0] && cfg_q[1] && qual_sel) |=> trig_out);

  // R7: a source or polarity change never yields an edge from the change itself
  p_hist_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_data[1] &&
     ((cfg_data[4] != cfg_q[3]) || (cfg_data[2] != cfg_q[2])))
    |=> ##1 (!trig_out || cfg_q[1]));

  // R1: reset leaves the output low
  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !trig_out);
endmodule

bind acq_trig_detect acq_trig_detect_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_wr  (cfg_wr),
  .cfg_data(cfg_data),
  .cfg_q   (cfg_q),
  .qual_sel(qual_sel),
  .trig_out(trig_out)
);

// File: tb/acq_trig_detect_tb_top.sv
module acq_trig_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [15:0] cfg_data;
  logic        ttl_in;
  logic        cmp_in;
  logic        trig_out;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int unsigned pulses = 0;
  bit          done = 1'b0;

  // bench reference state
  logic        m_t1, m_t2, m_c1, m_c2, m_prev, m_hv, m_out;
  logic [15:0] m_cfg;

  always #10 clk = ~clk;

  acq_trig_detect dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .ttl_in(ttl_in), .cmp_in(cmp_in), .trig_out(trig_out)
  );

  function automatic logic expect_next(input logic [15:0] cfg, input logic t2,
                                       input logic c2, input logic prev, input logic hv);
    logic sel;
    sel = (cfg[4] ? t2 : c2) ^ cfg[2];
    if (!cfg[0]) return 1'b0;
    if (cfg[1])  return sel;
    return sel && !prev && hv;
  endfunction

  task automatic model_reset();
    m_t1 = 0; m_t2 = 0; m_c1 = 0; m_c2 = 0;
    m_prev = 0; m_hv = 0; m_out = 0; m_cfg = '0;
  endtask

  task automatic model_edge(input logic t, input logic c, input logic w, input logic [15:0] d);
    logic sel, chg;
    sel    = (m_cfg[4] ? m_t2 : m_c2) ^ m_cfg[2];
    m_out  = expect_next(m_cfg, m_t2, m_c2, m_prev, m_hv);
    chg    = w && ((d[4] != m_cfg[4]) || (d[2] != m_cfg[2]));
    m_prev = sel;
    m_hv   = !chg;
    m_t2 = m_t1; m_t1 = t; m_c2 = m_c1; m_c1 = c;
    if (w) m_cfg = d;
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: trig_out=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_cnt(input string tag, input int unsigned act, input int unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: pulse count=%0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive, let one posedge pass, compare at the next negedge
  task automatic step(input logic t, input logic c, input logic w, input logic [15:0] d,
                      input string tag);
    ttl_in = t; cmp_in = c; cfg_wr = w; cfg_data = d;
    @(posedge clk);
    model_edge(t, c, w, d);
    @(negedge clk);
    cfg_wr = 1'b0;
    if (trig_out === 1'b1) pulses++;
    check(tag, trig_out, m_out);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(ttl_in, cmp_in, 1'b0, cfg_data, tag);
  endtask

  function automatic string mode_tag(input logic [15:0] cfg);
    if (!cfg[0]) return "R2";
    if (cfg[1])  return "R4";
    return "R3";
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_0a17));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_data = '0; ttl_in = 1'b1; cmp_in = 1'b1;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", trig_out, 1'b0);
    ttl_in = 1'b0; cmp_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", trig_out, 1'b0);

    // R1: inputs moving while still disarmed after reset
    step(1, 1, 0, 16'h0000, "R1"); idle(4, "R1");
    step(0, 0, 0, 16'h0000, "R1"); idle(4, "R1");

    // R3: rising edge on comparator, one pulse, third edge
    step(0, 0, 1, 16'h0001, "R10");
    idle(3, "R3");
    pulses = 0;
    step(0, 1, 0, 16'h0001, "R3");
    step(0, 1, 0, 16'h0001, "R3");
    step(0, 1, 0, 16'h0001, "R3");
    check("R3", trig_out, 1'b1);
    idle(5, "R3");
    check_cnt("R3", pulses, 1);

    // R5: falling edge
    step(0, 1, 1, 16'h0005, "R5"); idle(3, "R5");
    pulses = 0;
    step(0, 0, 0, 16'h0005, "R5"); idle(5, "R5");
    check_cnt("R5", pulses, 1);

    // R4/R5: level below threshold held
    step(0, 0, 1, 16'h0007, "R4"); idle(3, "R4");
    check("R5", trig_out, 1'b1);
    idle(6, "R4");
    check("R4", trig_out, 1'b1);
    step(0, 1, 0, 16'h0007, "R4"); idle(3, "R4");
    check("R5", trig_out, 1'b0);

    // R6: logic-level source ignores comparator
    step(0, 0, 1, 16'h0011, "R6"); idle(3, "R6");
    pulses = 0;
    for (int k = 0; k < 6; k++) begin
      step(0, 1, 0, 16'h0011, "R6"); idle(2, "R6");
      step(0, 0, 0, 16'h0011, "R6"); idle(2, "R6");
    end
    check_cnt("R6", pulses, 0);
    step(1, 0, 0, 16'h0011, "R6"); idle(4, "R6");
    check_cnt("R6", pulses, 1);

    // R7: polarity flip while input low must not look like an edge
    step(0, 0, 1, 16'h0001, "R7"); idle(4, "R7");
    pulses = 0;
    step(0, 0, 1, 16'h0005, "R7"); idle(6, "R7");
    check_cnt("R7", pulses, 0);
    // source swap with ttl high, comparator low
    step(1, 0, 1, 16'h0001, "R7"); idle(4, "R7");
    pulses = 0;
    step(1, 0, 1, 16'h0011, "R7"); idle(6, "R7");
    check_cnt("R7", pulses, 0);

    // R9: spare bits set change nothing
    step(0, 0, 1, 16'hFFE9, "R9"); idle(4, "R9");
    pulses = 0;
    step(0, 1, 0, 16'hFFE9, "R9"); idle(5, "R9");
    check_cnt("R9", pulses, 1);

    // R8: two-write disarm from an active level trigger
    step(0, 1, 1, 16'h0003, "R8"); idle(4, "R8");
    check("R4", trig_out, 1'b1);
    step(0, 1, 1, 16'h0002, "R8");
    step(0, 1, 1, 16'h0012, "R8");
    pulses = 0;
    for (int k = 0; k < 8; k++) step(k[0], k[1], 0, 16'h0012, "R8");
    idle(3, "R8");
    check_cnt("R8", pulses, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic        t, c, w;
      logic [15:0] d;
      t = ttl_in; c = cmp_in;
      if ($urandom_range(0, 5) == 0) t = ~t;
      if ($urandom_range(0, 5) == 0) c = ~c;
      w = ($urandom_range(0, 19) == 0);
      d = w ? 16'($urandom()) : cfg_data;
      if (w && $urandom_range(0, 3) != 0) d[0] = 1'b1;
      step(t, c, w, d, mode_tag(m_cfg));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule